// File: doc/BRIEF.md
# Serial SRAM Command Decoder Slave

This block is the device side of a serial SRAM link, written as synthesizable logic with a small internal byte array. It runs on a fast system clock. It oversamples the chip enable, the serial clock and four data lanes, and it decodes one command per chip-enable window. Depending on the command, it reads or writes the array, returns a fixed identification word, or changes the link mode.

The link has two modes: single-lane and four-lane. In four-lane mode the command, address and data phases all use four lanes. In single-lane mode a few commands still move their address and data over four lanes. Some commands are legal in only one mode. A soft reset needs a two-command sequence. The block is meant as a checkable partner for a host controller. Its array depth is a power-of-two parameter, and addresses are taken modulo that depth.

Top module: `ssram_slave`

## Requirements
- R1: After reset the link is in single-lane mode, `qpi_mode` is 0 and `sio_oe` is 0.
- R2: In single-lane mode the command byte and the 24 address bits arrive MSB first on lane 0. Read data leaves MSB first on lane 1, with `sio_oe`=0010, and each bit changes after a falling SCLK edge. Opcode 0x03 has no wait cycles. Opcode 0x0B has 8 wait cycles.
- R3: In four-lane phases the high nibble comes first and `sio_oe`=1111. In single-lane mode, 0xEB and 0x38 send their address and data on four lanes. In four-lane mode every phase uses four lanes. The wait cycles are 6 for 0xEB in either mode and 4 for 0x0B in four-lane mode.
- R4: Opcodes 0x02 and 0x38 write the following data bytes into the array. In four-lane mode the two codes behave the same.
- R5: A burst moves linearly through the array. The start address is the received 24-bit address modulo DEPTH, and the address wraps from DEPTH-1 to 0.
- R6: 0x35 is legal only in single-lane mode and selects four-lane mode. 0xF5 is legal only in four-lane mode and selects single-lane mode. Neither change shows on `qpi_mode` until chip enable rises.
- R7: 0x99 returns the link to single-lane mode at the next chip-enable rise, but only if the previous command was 0x66. The armed state survives between transactions, and any other command in between disarms it.
- R8: 0x9F is legal only in single-lane mode. After 24 address bits, with no wait cycles, it returns the high ID byte, then the low ID byte, and repeats that pair on lane 1.
- R9: An unknown command, or one not legal in the current mode, is ignored until chip enable rises. No lane is driven, the array is not changed, and a pending reset is disarmed.
- R10: A rising chip enable ends any operation, and `sio_oe` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| sclk | input | 1 | Serial clock from the host |
| sio_in | input | 4 | Data lanes as driven by the host |
| sio_out | output | 4 | Data lanes as driven by the block |
| sio_oe | output | 4 | Per-lane output enable |
| qpi_mode | output | 1 | 1 while the link is in four-lane mode |

## Verification
The assertions assume that the host keeps `ce_n`, `sclk` and the lanes stable for several system clocks around every SCLK edge. They also assume that chip enable changes only while SCLK is low, so each sampled edge is clean and unambiguous. The stimulus keeps to this because every pin change in the bench is followed by four system clocks, and chip enable moves only between whole SCLK periods. Random transactions draw only opcodes that are legal in the current mode. The illegal and unknown codes come from separate directed sequences.

// File: rtl/ssram_pkg.sv
`timescale 1ns/1ps
package ssram_pkg;

  localparam int ADDR_BITS = 24;

  typedef enum logic [2:0] {
    K_NONE, K_READ, K_WRITE, K_RDID, K_ENTER, K_EXIT, K_RSTEN, K_RST
  } op_kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_ADDR, S_WAIT, S_RD, S_WR, S_HOLD
  } phase_e;

  typedef struct packed {
    op_kind_e   kind;
    logic       quad;
    logic [3:0] waits;
  } op_dec_t;

  // last beat index for a field of the given bit count
  function automatic logic [4:0] beat_last(input int bits, input logic quad);
    return quad ? 5'(bits / 4 - 1) : 5'(bits - 1);
  endfunction

  // shift one beat into a byte, MSB first
  function automatic logic [7:0] shift_in(input logic [7:0] cur, input logic [3:0] d,
                                          input logic quad);
    return quad ? {cur[3:0], d} : {cur[6:0], d[0]};
  endfunction

  // opcode decode; codes not legal in the current mode fall to K_NONE
  function automatic op_dec_t decode_op(input logic [7:0] op, input logic qpi);
    op_dec_t r;
    r.kind  = K_NONE;
    r.quad  = qpi;
    r.waits = 4'd0;
    case (op)
      8'h03: if (!qpi) r.kind = K_READ;
      8'h0B: begin r.kind = K_READ; r.waits = qpi ? 4'd4 : 4'd8; end
      8'hEB: begin r.kind = K_READ; r.quad = 1'b1; r.waits = 4'd6; end
      8'h02: r.kind = K_WRITE;
      8'h38: begin r.kind = K_WRITE; r.quad = 1'b1; end
      8'h35: if (!qpi) r.kind = K_ENTER;
      8'hF5: if (qpi) r.kind = K_EXIT;
      8'h66: r.kind = K_RSTEN;
      8'h99: r.kind = K_RST;
      8'h9F: if (!qpi) r.kind = K_RDID;
      default: r.kind = K_NONE;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ssram_sync.sv
`timescale 1ns/1ps
module ssram_sync (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       sclk,
  input  logic [3:0] sio_in,
  output logic       ce_s,
  output logic       ce_rise,
  output logic       sck_rise,
  output logic       sck_fall,
  output logic [3:0] din
);
  localparam int PW = 6;
  localparam logic [PW-1:0] PIN_RST = 6'b100000;

  logic [PW-1:0] m1, m2;
  logic ce_prev, sck_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1       <= PIN_RST;
      m2       <= PIN_RST;
      ce_prev  <= 1'b1;
      sck_prev <= 1'b0;
    end else begin
      m1       <= {ce_n, sclk, sio_in};
      m2       <= m1;
      ce_prev  <= m2[5];
      sck_prev <= m2[4];
    end
  end

  assign ce_s     = m2[5];
  assign ce_rise  = m2[5] & ~ce_prev;
  assign sck_rise = m2[4] & ~sck_prev & ~m2[5];
  assign sck_fall = ~m2[4] & sck_prev & ~m2[5];
  assign din      = m2[3:0];
endmodule

// File: rtl/ssram_mem.sv
`timescale 1ns/1ps
module ssram_mem #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/ssram_ctrl.sv
`timescale 1ns/1ps
module ssram_ctrl
  import ssram_pkg::*;
#(
  parameter int          AW     = 8,
  parameter logic [15:0] DEV_ID = 16'hC35A
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_s,
  input  logic          ce_rise,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic [3:0]    din,
  input  logic [7:0]    mem_rdata,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic [3:0]    sio_out,
  output logic [3:0]    sio_oe,
  output logic          qpi_mode
);
  localparam logic [AW-1:0] PTR_STEP = AW'(1);

  phase_e    st;
  op_dec_t   cur;
  logic [4:0]  cnt;
  logic [7:0]  cmd_sr, dsr, wsr;
  logic [23:0] addr_sr;
  logic [AW-1:0] ptr;
  logic armed, pend_enter, pend_exit, pend_rst, id_hi_next;

  // named internal events
  logic [7:0]  cmd_next, wr_next, rd_byte, id_byte;
  logic [23:0] addr_next;
  op_dec_t     dec_now;
  logic        cmd_done, addr_done, wait_done, byte_edge;
  phase_e      data_phase;

  assign cmd_next   = shift_in(cmd_sr, din, qpi_mode);
  assign dec_now    = decode_op(cmd_next, qpi_mode);
  assign cmd_done   = (st == S_CMD) && sck_rise && (cnt == beat_last(8, qpi_mode));
  assign addr_next  = cur.quad ? {addr_sr[19:0], din} : {addr_sr[22:0], din[0]};
  assign addr_done  = (st == S_ADDR) && sck_rise && (cnt == beat_last(ADDR_BITS, cur.quad));
  assign wait_done  = (st == S_WAIT) && sck_rise && (cnt == {1'b0, cur.waits - 4'd1});
  assign byte_edge  = (cnt == beat_last(8, cur.quad));
  assign wr_next    = shift_in(wsr, din, cur.quad);
  assign id_byte    = id_hi_next ? DEV_ID[15:8] : DEV_ID[7:0];
  assign rd_byte    = (cnt == 5'd0) ? ((cur.kind == K_RDID) ? id_byte : mem_rdata) : dsr;
  assign data_phase = (cur.kind == K_WRITE) ? S_WR : S_RD;

  assign mem_we    = (st == S_WR) && sck_rise && byte_edge;
  assign mem_wdata = wr_next;
  assign mem_addr  = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cur <= '0; cnt <= '0;
      cmd_sr <= '0; dsr <= '0; wsr <= '0; addr_sr <= '0; ptr <= '0;
      armed <= 1'b0; pend_enter <= 1'b0; pend_exit <= 1'b0; pend_rst <= 1'b0;
      id_hi_next <= 1'b1; qpi_mode <= 1'b0;
      sio_out <= '0; sio_oe <= '0;
    end else if (ce_s) begin
      st <= S_IDLE; cnt <= '0; sio_oe <= '0;
      if (ce_rise) begin
        if (pend_rst)        qpi_mode <= 1'b0;
        else if (pend_enter) qpi_mode <= 1'b1;
        else if (pend_exit)  qpi_mode <= 1'b0;
        pend_rst <= 1'b0; pend_enter <= 1'b0; pend_exit <= 1'b0;
      end
    end else begin
      case (st)
        S_IDLE: begin st <= S_CMD; cnt <= '0; end
        S_CMD: if (sck_rise) begin
          cmd_sr <= cmd_next;
          cnt    <= cnt + 5'd1;
          if (cmd_done) begin
            cnt   <= '0;
            cur   <= dec_now;
            armed <= (dec_now.kind == K_RSTEN);
            case (dec_now.kind)
              K_READ, K_WRITE, K_RDID: st <= S_ADDR;
              K_ENTER: begin pend_enter <= 1'b1; st <= S_HOLD; end
              K_EXIT:  begin pend_exit  <= 1'b1; st <= S_HOLD; end
              K_RST:   begin pend_rst   <= armed; st <= S_HOLD; end
              default: st <= S_HOLD;
            endcase
          end
        end
        S_ADDR: if (sck_rise) begin
          addr_sr <= addr_next;
          cnt     <= cnt + 5'd1;
          if (addr_done) begin
            cnt        <= '0;
            ptr        <= addr_next[AW-1:0];
            id_hi_next <= 1'b1;
            st         <= (cur.waits == 4'd0) ? data_phase : S_WAIT;
          end
        end
        S_WAIT: if (sck_rise) begin
          cnt <= cnt + 5'd1;
          if (wait_done) begin cnt <= '0; st <= data_phase; end
        end
        S_RD: if (sck_fall) begin
          sio_oe  <= cur.quad ? 4'hF : 4'h2;
          sio_out <= cur.quad ? rd_byte[7:4] : {2'b00, rd_byte[7], 1'b0};
          dsr     <= cur.quad ? {rd_byte[3:0], 4'h0} : {rd_byte[6:0], 1'b0};
          if (cnt == 5'd0) begin
            if (cur.kind == K_RDID) id_hi_next <= ~id_hi_next;
            else                    ptr <= ptr + PTR_STEP;
          end
          cnt <= byte_edge ? 5'd0 : cnt + 5'd1;
        end
        S_WR: if (sck_rise) begin
          wsr <= wr_next;
          cnt <= byte_edge ? 5'd0 : cnt + 5'd1;
          if (byte_edge) ptr <= ptr + PTR_STEP;
        end
        default: ;
      endcase
    end
  end

  // R10: a high chip enable releases every lane
  p_hiz_on_deselect_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ce_s |=> (sio_oe == 4'h0));

  // R2 / R3: lanes are driven as none, lane 1 alone, or all four
  p_oe_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sio_oe == 4'h0) || (sio_oe == 4'h2) || (sio_oe == 4'hF));

  // R6: the mode flag moves only on a chip-enable rise
  p_mode_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(qpi_mode) |-> $past(ce_rise));

  // R7: an armed reset always lands in single-lane mode
  p_reset_lands_spi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_rise && pend_rst) |=> !qpi_mode);

  // R9: an ignored or finished command never drives a lane
  p_hold_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD) |-> (sio_oe == 4'h0));
endmodule

// File: rtl/ssram_slave.sv
`timescale 1ns/1ps
module ssram_slave #(
  parameter int          DEPTH  = 256,
  parameter logic [15:0] DEV_ID = 16'hC35A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       sclk,
  input  logic [3:0] sio_in,
  output logic [3:0] sio_out,
  output logic [3:0] sio_oe,
  output logic       qpi_mode
);
  localparam int AW = $clog2(DEPTH);

  logic ce_s, ce_rise, sck_rise, sck_fall;
  logic [3:0] din;
  logic mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;

  ssram_sync u_sync (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .sclk(sclk), .sio_in(sio_in),
    .ce_s(ce_s), .ce_rise(ce_rise), .sck_rise(sck_rise), .sck_fall(sck_fall), .din(din)
  );

  ssram_ctrl #(.AW(AW), .DEV_ID(DEV_ID)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ce_s(ce_s), .ce_rise(ce_rise),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .din(din),
    .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .sio_out(sio_out), .sio_oe(sio_oe), .qpi_mode(qpi_mode)
  );

  ssram_mem #(.DEPTH(DEPTH)) u_mem (
    .clk(clk), .we(mem_we), .addr(mem_addr), .wdata(mem_wdata), .rdata(mem_rdata)
  );
endmodule

// File: tb/ssram_slave_test.sv
`timescale 1ns/1ps
module ssram_slave_test;
  localparam int          DEPTH  = 256;
  localparam logic [15:0] DEV_ID = 16'hC35A;

  logic clk = 1'b0, rst_n = 1'b0, ce_n = 1'b1, sclk = 1'b0;
  logic [3:0] sio_in = 4'h0;
  wire  [3:0] sio_out, sio_oe;
  wire        qpi_mode;

  always #2 clk = ~clk;

  ssram_slave #(.DEPTH(DEPTH), .DEV_ID(DEV_ID)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .sclk(sclk), .sio_in(sio_in),
    .sio_out(sio_out), .sio_oe(sio_oe), .qpi_mode(qpi_mode)
  );

  int n_chk = 0, n_bad = 0;
  logic [7:0] model [DEPTH];
  logic [7:0] wbuf [8];
  bit m_qpi = 0, m_armed = 0;
  logic [3:0] oe_acc;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int wait_of(input logic [7:0] op, input bit qpi);
    if (op == 8'h0B) return qpi ? 4 : 8;
    if (op == 8'hEB) return 6;
    return 0;
  endfunction
  function automatic bit quad_of(input logic [7:0] op, input bit qpi);
    return qpi || op == 8'hEB || op == 8'h38;
  endfunction
  function automatic int wrap(input longint a);
    return int'(a % DEPTH);
  endfunction

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask
  task automatic sbit(input logic [3:0] d, output logic [3:0] q);
    sio_in = d; tick(4); q = sio_out; oe_acc |= sio_oe;
    sclk = 1'b1; tick(4); sclk = 1'b0;
  endtask
  task automatic tx_begin(); ce_n = 1'b0; tick(4); oe_acc = 4'h0; endtask
  task automatic tx_end(); tick(4); ce_n = 1'b1; tick(8); endtask
  task automatic put_byte(input logic [7:0] b, input bit quad);
    logic [3:0] q;
    if (quad) begin sbit(b[7:4], q); sbit(b[3:0], q); end
    else for (int i = 7; i >= 0; i--) sbit({3'b000, b[i]}, q);
  endtask
  task automatic put_addr(input logic [23:0] a, input bit quad);
    put_byte(a[23:16], quad); put_byte(a[15:8], quad); put_byte(a[7:0], quad);
  endtask
  task automatic get_byte(input bit quad, output logic [7:0] b);
    logic [3:0] q;
    if (quad) begin sbit(4'h0, q); b[7:4] = q; sbit(4'h0, q); b[3:0] = q; end
    else for (int i = 7; i >= 0; i--) begin sbit(4'h0, q); b[i] = q[1]; end
  endtask
  task automatic dummy(input int n);
    logic [3:0] q;
    repeat (n) sbit(4'h0, q);
  endtask

  task automatic do_write(input logic [7:0] op, input logic [23:0] a, input int n);
    bit qd = quad_of(op, m_qpi);
    tx_begin(); put_byte(op, m_qpi); put_addr(a, qd);
    for (int i = 0; i < n; i++) begin put_byte(wbuf[i], qd); model[wrap(a + i)] = wbuf[i]; end
    tx_end(); m_armed = 0;
  endtask
  task automatic do_read(input logic [7:0] op, input logic [23:0] a, input int n, input string tag);
    bit qd = quad_of(op, m_qpi);
    logic [7:0] b;
    tx_begin(); put_byte(op, m_qpi); put_addr(a, qd); dummy(wait_of(op, m_qpi));
    for (int i = 0; i < n; i++) begin
      get_byte(qd, b);
      check(b == model[wrap(a + i)], tag, b, model[wrap(a + i)]);
    end
    check(oe_acc == (qd ? 4'hF : 4'h2), {tag, " lane enables"}, oe_acc, qd ? 4'hF : 4'h2);
    tx_end(); m_armed = 0;
  endtask
  task automatic run_simple(input logic [7:0] op);
    bit rst_now = (op == 8'h99) && m_armed;
    tx_begin(); put_byte(op, m_qpi); tx_end();
    if (rst_now) m_qpi = 0;
    else if (op == 8'h35 && !m_qpi) m_qpi = 1;
    else if (op == 8'hF5 && m_qpi) m_qpi = 0;
    m_armed = (op == 8'h66);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] b;
    logic [7:0] rops_s [3] = '{8'h03, 8'h0B, 8'hEB};
    logic [7:0] rops_q [2] = '{8'h0B, 8'hEB};
    void'($urandom(32'd20240607));
    tick(5); rst_n = 1'b1; tick(5);
    check(sio_oe == 4'h0, "R1 lanes idle after reset", sio_oe, 0);
    check(qpi_mode == 1'b0, "R1 single-lane after reset", qpi_mode, 0);

    // R8: identification word in single-lane mode
    tx_begin(); put_byte(8'h9F, 0); put_addr(24'h000000, 0);
    get_byte(0, b); check(b == DEV_ID[15:8], "R8 id high", b, DEV_ID[15:8]);
    get_byte(0, b); check(b == DEV_ID[7:0], "R8 id low", b, DEV_ID[7:0]);
    get_byte(0, b); check(b == DEV_ID[15:8], "R8 id repeats", b, DEV_ID[15:8]);
    check(oe_acc == 4'h2, "R8 lane 1 only", oe_acc, 2);
    tx_end();

    // R2 / R4: serial write, then both serial reads
    wbuf[0] = 8'h3C; wbuf[1] = 8'hA1; wbuf[2] = 8'h7E;
    do_write(8'h02, 24'h000010, 3);
    do_read(8'h03, 24'h000010, 3, "R2 R4 read 0x03");
    do_read(8'h0B, 24'h000010, 3, "R2 read 0x0B");
    // R3: four-lane write/read from single-lane mode
    wbuf[0] = 8'h5D; wbuf[1] = 8'hE2;
    do_write(8'h38, 24'h000020, 2);
    do_read(8'hEB, 24'h000020, 2, "R3 quad read in single-lane mode");

    // R5: wrap at the top and high address bits discarded
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    do_write(8'h02, 24'hABCD00 | 24'(DEPTH - 1), 3);
    do_read(8'h03, 24'h000000, 2, "R5 wrap to zero");
    do_read(8'h0B, 24'h123400 | 24'(DEPTH - 1), 3, "R5 burst across top");

    // R10: chip enable rise in the middle of a read
    tx_begin(); put_byte(8'h03, 0); put_addr(24'h000010, 0);
    get_byte(0, b); check(b == model[16], "R10 first byte", b, model[16]);
    tick(4); ce_n = 1'b1; tick(8);
    check(sio_oe == 4'h0, "R10 lanes released", sio_oe, 0);

    // R9: unknown command with trailing bytes leaves the array alone
    tx_begin(); put_byte(8'hA7, 0); put_addr(24'h000010, 0); put_byte(8'h00, 0);
    check(oe_acc == 4'h0, "R9 unknown drives nothing", oe_acc, 0);
    tx_end();
    do_read(8'h03, 24'h000010, 1, "R9 array unchanged");

    // R6: F5 in single-lane mode is ignored
    run_simple(8'hF5);
    check(qpi_mode == 1'b0, "R6 exit ignored in single-lane", qpi_mode, 0);
    // R6: mode change held until chip enable rises
    tx_begin(); put_byte(8'h35, 0); tick(4);
    check(qpi_mode == 1'b0, "R6 change held while selected", qpi_mode, 0);
    tx_end(); m_qpi = 1; m_armed = 0;
    check(qpi_mode == 1'b1, "R6 four-lane after deselect", qpi_mode, 1);

    // R9: single-lane-only reads ignored in four-lane mode
    tx_begin(); put_byte(8'h9F, 1); put_addr(24'h0, 1); dummy(4);
    check(oe_acc == 4'h0, "R9 id read ignored in four-lane", oe_acc, 0);
    tx_end(); m_armed = 0;
    tx_begin(); put_byte(8'h03, 1); put_addr(24'h000010, 1); dummy(4);
    check(oe_acc == 4'h0, "R9 slow read ignored in four-lane", oe_acc, 0);
    tx_end(); m_armed = 0;
    run_simple(8'h35);
    check(qpi_mode == 1'b1, "R6 enter ignored in four-lane", qpi_mode, 1);

    // R3 / R4: both write codes, four-lane reads
    wbuf[0] = 8'hC7; wbuf[1] = 8'h48;
    do_write(8'h38, 24'h000030, 2);
    wbuf[0] = 8'h9B;
    do_write(8'h02, 24'h000032, 1);
    do_read(8'h0B, 24'h000030, 3, "R3 R4 four-lane 0x0B");
    do_read(8'hEB, 24'h000030, 3, "R3 four-lane 0xEB");

    // R7: interrupted reset sequence does nothing
    run_simple(8'h66); run_simple(8'hA7); run_simple(8'h99);
    check(qpi_mode == 1'b1, "R7 R9 disarmed reset", qpi_mode, 1);
    // R7: armed reset across transactions
    run_simple(8'h66); run_simple(8'h99);
    check(qpi_mode == 1'b0, "R7 reset to single-lane", qpi_mode, 0);

    // random traffic
    for (int it = 0; it < 40; it++) begin
      int n;
      logic [23:0] a;
      logic [7:0] wop, rop;
      if (it % 10 == 9) begin
        run_simple(m_qpi ? 8'hF5 : 8'h35);
        check(qpi_mode == m_qpi, "R6 random mode toggle", qpi_mode, m_qpi);
      end
      n = 1 + int'($urandom % 4);
      a = 24'($urandom);
      if (it % 4 == 0) a = {a[23:8], 8'h00} | 24'(DEPTH - 1 - int'($urandom % 2));
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      wop = ($urandom % 2 == 0) ? 8'h02 : 8'h38;
      rop = m_qpi ? rops_q[$urandom % 2] : rops_s[$urandom % 3];
      do_write(wop, a, n);
      do_read(rop, a, n, quad_of(rop, m_qpi) ? "R3 R4 R5 random read" : "R2 R4 R5 random read");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule